// File: doc/BRIEF.md
# Seven-to-one serializer with training insertion

The block turns a parallel word of seven bits per data lane into serial streams. It sends one bit per lane on each pulse of a bit-rate enable, which runs at seven times the word rate. The most significant bit of each seven-bit symbol goes first. A companion clock lane sends a seven-bit framing pattern in step with the data, so the receiver can recover the word boundary.

When the active-low training request is low at a symbol boundary, the block stops sending user data. Every data lane then carries a fixed training word, and the clock lane switches to an alternate framing pattern, so the receiver knows in-band that it should calibrate its sampling strobes. The request should stay low for at least four whole symbols. The block counts completed training symbols and raises a flag once that minimum has been met. A power-down input clears the serializer and drops the output enable, which stands for putting the line drivers in high impedance. A parameter picks one of two framing variants.

Top module: `ser7_serializer`

## Requirements
- R1: On each cycle with `bit_en` high, each `ser_data` lane moves to the next bit of its current seven-bit symbol, bit 6 of the loaded slice first and bit 0 last. Lane i's slice is `par_data[7*i+6 : 7*i]`.
- R2: In normal mode the clock lane sends 1111000 for VARIANT 0 and 1110000 for VARIANT 1 in each symbol, leftmost bit first.
- R3: In training mode the clock lane sends 1111100 for VARIANT 0 and 1100000 for VARIANT 1.
- R4: In training mode every data lane sends the training word, leftmost bit first, whatever `par_data` holds. The word is 1111000 for VARIANT 0 and 1110000 for VARIANT 1.
- R5: `par_data` and `train_req_n` are sampled only on a clock edge where `word_take` is high. `word_take` is high exactly when `bit_en` is high, `pwr_dn` is low and the previous symbol has finished. A change in `train_req_n` at any other time has no effect on the symbol being sent.
- R6: `train_ok` rises at the symbol boundary where a fifth consecutive training symbol starts, which means four whole training symbols have been sent. It falls at the boundary where a normal symbol is loaded, and on power-down.
- R7: Power-down (`pwr_dn` high at an edge) drives `out_en` low one cycle later. The same edge clears the serial outputs and the symbol position. The first `bit_en` after `pwr_dn` falls loads a fresh symbol, and `out_en` returns high one cycle after `pwr_dn` falls.
- R8: A cycle with `bit_en` low leaves all serial outputs and the symbol position unchanged.
- R9: During reset, `ser_data`, `ser_clk`, `out_en` and `train_ok` are 0. The first `bit_en` after reset loads a symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Serial bit enable, one pulse per serial bit |
| train_req_n | input | 1 | Active-low training request, sampled at symbol boundaries |
| pwr_dn | input | 1 | Power-down request |
| par_data | input | 7*LANES | Parallel word, seven bits per lane |
| ser_data | output | LANES | Serial data lanes |
| ser_clk | output | 1 | Serial framing clock lane |
| out_en | output | 1 | Output-driver enable, low in power-down |
| word_take | output | 1 | Parallel word and training request are taken at this edge |
| train_ok | output | 1 | Training minimum of four symbols has been met |

## Verification
The serial outputs change at the clock edge where `bit_en` is seen, so the first bit of a new symbol appears one edge after the `word_take` edge. `out_en` follows `pwr_dn` one edge later, and `train_ok` changes at the same boundary edge that loads the deciding symbol. `word_take` is combinational and is valid in the same cycle as `bit_en`. The bench runs a behavioural model that updates at each rising edge from the inputs it drove. Registered outputs are compared at the falling edge, before new inputs are driven, and `word_take` is compared one time unit after the inputs change. Both framing variants run side by side on the same stimulus.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int SYM_BITS = 7;
  typedef logic [SYM_BITS-1:0] sym_t;

  // Framing pattern of the clock lane; variant picks the pulse width pair.
  function automatic sym_t frame_pattern(input int variant, input logic training);
    sym_t p;
    if (variant == 0) p = training ? 7'b1111100 : 7'b1111000;
    else              p = training ? 7'b1100000 : 7'b1110000;
    return p;
  endfunction

  // The training word equals the normal framing pattern of the variant.
  function automatic sym_t training_word(input int variant);
    return frame_pattern(variant, 1'b0);
  endfunction
endpackage

// File: rtl/ser7_bit_timer.sv
module ser7_bit_timer #(
  parameter int SYM_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_en,
  output logic load,
  output logic shift
);
  localparam int CW = $clog2(SYM_BITS);
  localparam logic [CW-1:0] LAST = CW'(SYM_BITS - 1);

  logic [CW-1:0] pos;
  logic          at_last;

  assign at_last = (pos == LAST);
  assign load    = bit_en && !clr && at_last;
  assign shift   = bit_en && !clr && !at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= LAST;
    else if (clr)    pos <= LAST;
    else if (bit_en) pos <= at_last ? '0 : pos + 1'b1;
  end

  // R8: no enable, no movement of the symbol position
  p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clr) |=> $stable(pos));
  // R1: a load is always followed by a shift-phase position
  p_load_then_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !at_last);
endmodule

// File: rtl/ser7_shifter.sv
module ser7_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         sout
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clr)   sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign sout = sr[W-1];

  // R1: loaded value shows its top bit on the next cycle
  p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (sout == $past(load_val[W-1])));
endmodule

// File: rtl/ser7_train_mon.sv
module ser7_train_mon #(
  parameter int MIN_SYMS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic req_n,
  output logic mode,
  output logic ok
);
  localparam int RW = $clog2(MIN_SYMS + 1);
  localparam logic [RW-1:0] MAXR = RW'(MIN_SYMS);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 1'b0;
      run  <= '0;
    end else if (clr) begin
      mode <= 1'b0;
      run  <= '0;
    end else if (load) begin
      mode <= !req_n;
      if (req_n)          run <= '0;
      else if (!mode)     run <= '0;
      else if (run != MAXR) run <= run + 1'b1;
    end
  end

  assign ok = (run >= MAXR);

  // R5: the mode only changes at a symbol boundary
  p_mode_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(mode));
  // R6: the flag is only up while training symbols are sent
  p_ok_in_training_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> mode);
endmodule

// File: rtl/ser7_serializer.sv
module ser7_serializer
  import ser7_pkg::*;
#(
  parameter int LANES          = 4,
  parameter int VARIANT        = 0,
  parameter int MIN_TRAIN_SYMS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic                      train_req_n,
  input  logic                      pwr_dn,
  input  logic [SYM_BITS*LANES-1:0] par_data,
  output logic [LANES-1:0]          ser_data,
  output logic                      ser_clk,
  output logic                      out_en,
  output logic                      word_take,
  output logic                      train_ok
);
  localparam sym_t TRAIN_WORD = training_word(VARIANT);
  localparam sym_t CLK_NORM   = frame_pattern(VARIANT, 1'b0);
  localparam sym_t CLK_TRAIN  = frame_pattern(VARIANT, 1'b1);

  logic load, shift, train_mode;
  sym_t clk_sym;

  ser7_bit_timer #(.SYM_BITS(SYM_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .bit_en(bit_en),
    .load(load), .shift(shift)
  );

  ser7_train_mon #(.MIN_SYMS(MIN_TRAIN_SYMS)) u_mon (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .load(load),
    .req_n(train_req_n), .mode(train_mode), .ok(train_ok)
  );

  assign clk_sym = train_req_n ? CLK_NORM : CLK_TRAIN;

  ser7_shifter #(.W(SYM_BITS)) u_clk_lane (
    .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .load(load), .shift(shift),
    .load_val(clk_sym), .sout(ser_clk)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sym_t lane_sym;
    assign lane_sym = train_req_n ? par_data[g*SYM_BITS +: SYM_BITS] : TRAIN_WORD;
    ser7_shifter #(.W(SYM_BITS)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .load(load), .shift(shift),
      .load_val(lane_sym), .sout(ser_data[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_en <= 1'b0;
    else        out_en <= !pwr_dn;
  end

  assign word_take = load;

  // R8: serial outputs hold without a bit enable
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !pwr_dn) |=> ($stable(ser_data) && $stable(ser_clk)));
  // R7: power-down drops the driver enable on the next cycle
  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !out_en);
  // R3: a training symbol starts with a high clock-lane bit and raises the mode
  p_train_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_take && !train_req_n) |=> (ser_clk && train_mode));
endmodule

// File: tb/ser7_serializer_test.sv
module ser7_serializer_test;
  localparam int LANES = 4;
  localparam int MINS  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, train_req_n = 1'b1, pwr_dn = 1'b0;
  logic [7*LANES-1:0] par_data = '0;
  logic [LANES-1:0] sd0, sd1;
  logic sc0, sc1, oe0, oe1, wt0, wt1, ok0, ok1;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ser7_serializer #(.LANES(LANES), .VARIANT(0), .MIN_TRAIN_SYMS(MINS)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .train_req_n(train_req_n),
    .pwr_dn(pwr_dn), .par_data(par_data), .ser_data(sd0), .ser_clk(sc0),
    .out_en(oe0), .word_take(wt0), .train_ok(ok0));

  ser7_serializer #(.LANES(LANES), .VARIANT(1), .MIN_TRAIN_SYMS(MINS)) uut_v1 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .train_req_n(train_req_n),
    .pwr_dn(pwr_dn), .par_data(par_data), .ser_data(sd1), .ser_clk(sc1),
    .out_en(oe1), .word_take(wt1), .train_ok(ok1));

  // Behavioural model: symbol content plus a bit index counting down.
  int m_loaded, m_k, m_run, m_train, m_oe;
  int m_word[LANES];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || pwr_dn) begin
      m_loaded = 0; m_k = 0; m_run = 0; m_train = 0;
      for (int l = 0; l < LANES; l++) m_word[l] = 0;
      m_oe = rst_n ? 0 : 0;
    end else begin
      m_oe = 1;
      if (bit_en) begin
        if (m_loaded == 0 || m_k == 0) begin
          m_train = train_req_n ? 0 : 1;
          m_run   = m_train ? m_run + 1 : 0;
          for (int l = 0; l < LANES; l++) m_word[l] = (par_data >> (7*l)) & 7'h7f;
          m_loaded = 1; m_k = 6;
        end else m_k = m_k - 1;
      end
    end
  end

  function automatic int clk_word(int v, int tr);
    if (v == 0) return tr ? 124 : 120;
    return tr ? 96 : 112;
  endfunction

  function automatic int exp_data(int v, int l);
    int w;
    if (m_loaded == 0) return 0;
    w = m_train ? clk_word(v, 0) : m_word[l];
    return (w >> m_k) & 1;
  endfunction

  function automatic int exp_clk(int v);
    if (m_loaded == 0) return 0;
    return (clk_word(v, m_train) >> m_k) & 1;
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string dtag;
    dtag = m_train ? "R4" : "R1/R8";
    for (int l = 0; l < LANES; l++) begin
      chk(int'(sd0[l]) == exp_data(0, l), dtag, int'(sd0[l]), exp_data(0, l));
      chk(int'(sd1[l]) == exp_data(1, l), dtag, int'(sd1[l]), exp_data(1, l));
    end
    chk(int'(sc0) == exp_clk(0), m_train ? "R3" : "R2", int'(sc0), exp_clk(0));
    chk(int'(sc1) == exp_clk(1), m_train ? "R3" : "R2", int'(sc1), exp_clk(1));
    chk(int'(oe0) == m_oe && int'(oe1) == m_oe, "R7", int'(oe0), m_oe);
    chk(int'(ok0) == int'(m_run >= MINS + 1) && ok0 == ok1, "R6", int'(ok0),
        int'(m_run >= MINS + 1));
  endtask

  task automatic step(input bit be, input bit tn, input bit pd);
    int ew;
    @(negedge clk);
    compare_all();
    bit_en = be; train_req_n = tn; pwr_dn = pd;
    par_data = (7*LANES)'($urandom());
    #1;
    ew = (be && !pd && (m_loaded == 0 || m_k == 0)) ? 1 : 0;
    chk(int'(wt0) == ew && wt0 == wt1, "R5", int'(wt0), ew);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(sd0 == '0 && sc0 == 1'b0 && sd1 == '0 && sc1 == 1'b0, "R9", int'(sd0), 0);
      chk(oe0 == 1'b0 && ok0 == 1'b0, "R9", int'(oe0), 0);
    end
    rst_n = 1'b1;
    repeat (70)  step(1'b1, 1'b1, 1'b0);                       // R1 R2
    repeat (120) step(($urandom() % 3) != 0, 1'b1, 1'b0);      // R8 gaps
    for (int i = 0; i < 100; i++) step(1'b1, (i % 7) == 3, 1'b0); // R5 mid toggles
    repeat (70)  step(1'b1, 1'b0, 1'b0);                       // R3 R4 R6
    repeat (30)  step(1'b1, 1'b1, 1'b0);
    repeat (14)  step(1'b1, 1'b0, 1'b0);                       // R6 short run
    repeat (30)  step(1'b1, 1'b1, 1'b0);
    repeat (80)  step(($urandom() % 2) != 0, 1'b0, 1'b0);      // R8 in training
    repeat (6)   step(1'b1, 1'b0, 1'b1);                       // R7
    repeat (60)  step(1'b1, 1'b1, 1'b0);
    repeat (4)   step(1'b1, 1'b1, 1'b0);
    repeat (3)   step(1'b1, 1'b1, 1'b1);                       // R7 mid-symbol
    repeat (40)  step(1'b1, 1'b0, 1'b0);
    repeat (20)  step(1'b1, 1'b1, 1'b0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule